// File: doc/BRIEF.md
# Descriptor-Ring Memory Copy Engine

This block moves blocks of words from one memory address to another without processor help. Software describes each job as a four-word descriptor and places it in a circular table in memory. It then programs the table's base address and its slot count, and moves a tail index forward. The engine owns a head index. Whenever head and tail differ, it reads the descriptor at the head slot, copies the requested number of words through a single word-wide memory port, and moves the head on by one slot. The head returns to slot zero when it reaches the slot count.

No start command exists. The engine rests while the two indexes are equal and wakes on its own once the tail moves. New descriptors can therefore be appended while a copy is still running. Each completed descriptor sets a sticky completion flag. A descriptor can also request an interrupt, and the interrupt output is further gated by a global enable. The priority bits of a descriptor are held and shown on an output, but jobs always run in ring order.

Memory addresses count words. Descriptor slot `h` occupies words `base + 4*h` up to `base + 4*h + 3`.

Top module: `ring_copy_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `head_o` is 0 and `mem_req`, `busy`, `done_flag` and `irq` are all 0.
- R2: For the head slot, the engine reads four descriptor words at `cfg_base + 4*head + k`. Word k=0 is the source address, k=1 the destination address, k=2 the length in words (low 16 bits) and k=3 the flags. It then copies word i from `src+i` to `dst+i` for i = 0 up to length-1, in ascending order, with each read followed by its write.
- R3: While `head_o` equals `cfg_tail` bit for bit and the engine is not busy, it issues no memory request and `head_o` does not change.
- R4: Moving `cfg_tail` is enough to start processing. A descriptor appended and published while an earlier copy is running is executed after that copy finishes, with no further command.
- R5: Each completed descriptor advances `head_o` by exactly one. When the incremented value equals `cfg_size`, `head_o` becomes 0 instead.
- R6: `done_flag` becomes 1 on every completion and stays 1 until a cycle in which `done_clr` is 1. If a completion and `done_clr` fall in the same cycle, the flag ends up 1.
- R7: An interrupt is pending after a completion only if bit 0 of that descriptor's flags word is 1. `irq` is 1 exactly when an interrupt is pending and `irq_en` is 1. `done_clr` also clears a pending interrupt.
- R8: A descriptor with length 0 causes only its four descriptor reads and no data read or write. It still advances the head and sets the flag and interrupt as in R5 to R7.
- R9: Bits 3:1 of the flags word appear on `cur_prio` once the descriptor has been fetched. Descriptors run in ring order whatever their priority.
- R10: A memory request that sees `mem_ready` at 0 is held in the next cycle with the same address, write strobe and write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 16 | Word address of descriptor slot 0 |
| cfg_size | input | 5 | Number of slots in the ring |
| cfg_tail | input | 4 | Software-owned slot index one past the last queued descriptor |
| head_o | output | 4 | Engine-owned index of the next slot to process |
| irq_en | input | 1 | Global interrupt enable |
| done_clr | input | 1 | Clears the completion flag and the pending interrupt |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Engine is working on a descriptor |
| cur_prio | output | 3 | Priority field of the latest fetched descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 16 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_rdata | input | 32 | Read data, valid in the cycle `mem_ready` is 1 |

## Verification
Two functions can fall in the same cycle: a completion that sets the sticky flag, and a software clear. The bench holds `done_clr` high in every cycle while a descriptor runs. When the head is seen to move, the flag must read 1 in that very sample, and it must stay 1 once the clear is dropped. A second overlap is a tail update during a running copy. It is provoked while data writes are under way, and it is judged by a scoreboard that requires the appended job's writes to follow the earlier job's writes in order.

// File: rtl/rce_pkg.sv
package rce_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } rce_state_e;

  localparam int DESC_WORDS = 4;
  localparam int SLOT_SHIFT = $clog2(DESC_WORDS);
  localparam int FLG_IE_BIT = 0;
  localparam int PRIO_LSB   = 1;
  localparam int PRIO_W     = 3;
endpackage

// File: rtl/rce_ring_ctrl.sv
module rce_ring_ctrl #(
  parameter int AW = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [IW:0]   cfg_size,
  input  logic [IW-1:0] cfg_tail,
  input  logic          adv,
  output logic [IW-1:0] head,
  output logic          ring_empty,
  output logic [AW-1:0] slot_addr
);
  import rce_pkg::*;

  logic [IW-1:0] head_q, head_d;
  logic [IW:0]   head_inc;
  logic          wrap;

  always_comb begin
    head_inc = {1'b0, head_q} + (IW+1)'(1);
    wrap     = (head_inc == cfg_size);
    head_d   = head_q;
    if (adv) head_d = wrap ? '0 : head_inc[IW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   head_q <= '0;
    else if (adv) head_q <= head_d;
  end

  assign head       = head_q;
  assign ring_empty = ~|(head_q ^ cfg_tail);
  assign slot_addr  = cfg_base + (AW'(head_q) << SLOT_SHIFT);

  assert_head_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(head_q));
  assert_head_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cfg_size != (IW+1)'(1)) |=> head_q != $past(head_q));
endmodule

// File: rtl/rce_mover.sv
module rce_mover #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ring_empty,
  input  logic [AW-1:0] slot_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          complete,
  output logic          complete_ie,
  output logic          busy,
  output logic [rce_pkg::PRIO_W-1:0] prio
);
  import rce_pkg::*;

  rce_state_e        st_q, st_d;
  logic [1:0]        idx_q, idx_d;
  logic [AW-1:0]     src_q, src_d, dst_q, dst_d;
  logic [LW-1:0]     len_q, len_d, cnt_q, cnt_d;
  logic              ie_q, ie_d;
  logic [PRIO_W-1:0] prio_q, prio_d;
  logic [DW-1:0]     data_q, data_d;
  logic              acc;

  assign acc = mem_req & mem_ready;

  always_comb begin
    mem_req   = (st_q == ST_FETCH) || (st_q == ST_READ) || (st_q == ST_WRITE);
    mem_we    = (st_q == ST_WRITE);
    mem_wdata = data_q;
    case (st_q)
      ST_FETCH: mem_addr = slot_addr + AW'(idx_q);
      ST_READ:  mem_addr = src_q + AW'(cnt_q);
      ST_WRITE: mem_addr = dst_q + AW'(cnt_q);
      default:  mem_addr = '0;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    src_d  = src_q;
    dst_d  = dst_q;
    len_d  = len_q;
    cnt_d  = cnt_q;
    ie_d   = ie_q;
    prio_d = prio_q;
    data_d = data_q;
    case (st_q)
      ST_IDLE: begin
        if (!ring_empty) begin
          st_d  = ST_FETCH;
          idx_d = 2'd0;
        end
      end
      ST_FETCH: begin
        if (acc) begin
          idx_d = idx_q + 2'd1;
          case (idx_q)
            2'd0: src_d = mem_rdata[AW-1:0];
            2'd1: dst_d = mem_rdata[AW-1:0];
            2'd2: len_d = mem_rdata[LW-1:0];
            default: begin
              ie_d   = mem_rdata[FLG_IE_BIT];
              prio_d = mem_rdata[PRIO_LSB +: PRIO_W];
              cnt_d  = '0;
              st_d   = (len_q == '0) ? ST_DONE : ST_READ;
            end
          endcase
        end
      end
      ST_READ: begin
        if (acc) begin
          data_d = mem_rdata;
          st_d   = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (acc) begin
          if (cnt_q == len_q - LW'(1)) st_d = ST_DONE;
          else begin
            cnt_d = cnt_q + LW'(1);
            st_d  = ST_READ;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      ie_q   <= 1'b0;
      prio_q <= '0;
      data_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (st_q == ST_FETCH) begin
        src_q  <= src_d;
        dst_q  <= dst_d;
        len_q  <= len_d;
        ie_q   <= ie_d;
        prio_q <= prio_d;
      end
      if (st_q == ST_FETCH || st_q == ST_WRITE) cnt_q <= cnt_d;
      if (st_q == ST_READ) data_q <= data_d;
    end
  end

  assign complete    = (st_q == ST_DONE);
  assign complete_ie = ie_q;
  assign busy        = (st_q != ST_IDLE);
  assign prio        = prio_q;

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  assert_quiet_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && ring_empty) |=> !mem_req);
  assert_zero_len_no_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FETCH && idx_q == 2'd3 && acc && len_q == '0) |=> !mem_req);
endmodule

// File: rtl/rce_done_flag.sv
module rce_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic set_ie,
  input  logic clr,
  input  logic irq_en,
  output logic done_flag,
  output logic irq
);
  logic flag_q, flag_d, pend_q, pend_d;

  always_comb begin
    flag_d = set | (flag_q & ~clr);
    pend_d = (set & set_ie) | (pend_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      pend_q <= pend_d;
    end
  end

  assign done_flag = flag_q;
  assign irq       = pend_q & irq_en;

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);
  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q);
endmodule

// File: rtl/ring_copy_engine.sv
module ring_copy_engine #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int IW = 4,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [IW:0]   cfg_size,
  input  logic [IW-1:0] cfg_tail,
  output logic [IW-1:0] head_o,
  input  logic          irq_en,
  input  logic          done_clr,
  output logic          done_flag,
  output logic          irq,
  output logic          busy,
  output logic [rce_pkg::PRIO_W-1:0] cur_prio,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata
);
  logic          ring_empty, complete, complete_ie;
  logic [AW-1:0] slot_addr;

  rce_ring_ctrl #(.AW(AW), .IW(IW)) u_ring (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_tail(cfg_tail), .adv(complete), .head(head_o),
    .ring_empty(ring_empty), .slot_addr(slot_addr)
  );

  rce_mover #(.AW(AW), .DW(DW), .LW(LW)) u_mover (
    .clk(clk), .rst_n(rst_n), .ring_empty(ring_empty), .slot_addr(slot_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .complete(complete), .complete_ie(complete_ie), .busy(busy), .prio(cur_prio)
  );

  rce_done_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(complete), .set_ie(complete_ie),
    .clr(done_clr), .irq_en(irq_en), .done_flag(done_flag), .irq(irq)
  );
endmodule

// File: tb/ring_copy_engine_bench.sv
module ring_copy_engine_bench;
  localparam int AW = 16, DW = 32, IW = 4, LW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] cfg_base;
  logic [IW:0]   cfg_size;
  logic [IW-1:0] cfg_tail, head_o;
  logic          irq_en, done_clr, done_flag, irq, busy;
  logic [2:0]    cur_prio;
  logic          mem_req, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  ring_copy_engine #(.AW(AW), .DW(DW), .IW(IW), .LW(LW)) u_ring_copy_engine (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_tail(cfg_tail), .head_o(head_o), .irq_en(irq_en), .done_clr(done_clr),
    .done_flag(done_flag), .irq(irq), .busy(busy), .cur_prio(cur_prio),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  always #4 clk = ~clk;

  // memory model
  logic [DW-1:0] mem [0:1023];
  logic          tb_wr;
  logic [9:0]    tb_addr;
  logic [DW-1:0] tb_data;
  logic [7:0]    lfsr;

  assign mem_rdata = mem[mem_addr[9:0]];
  assign mem_ready = lfsr[0] | lfsr[3];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) lfsr <= 8'h5a;
    else        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  always @(posedge clk) begin
    if (tb_wr) mem[tb_addr] <= tb_data;
    if (rst_n && mem_req && mem_we && mem_ready) mem[mem_addr[9:0]] <= mem_wdata;
  end

  int nchk = 0, nfail = 0;
  int rd_cnt = 0, wr_cnt = 0, req_cnt = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard of expected writes
  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } wr_t;
  wr_t exp_q[$];

  logic          prev_stall;
  logic [AW-1:0] prev_addr;
  logic          prev_we;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(mem_req && mem_addr == prev_addr && mem_we == prev_we, "R10",
              "stalled request not held", int'(mem_addr), int'(prev_addr));
      if (mem_req) req_cnt++;
      if (mem_req && mem_ready && !mem_we) rd_cnt++;
      if (mem_req && mem_ready && mem_we) begin
        wr_cnt++;
        if (exp_q.size() == 0)
          check(1'b0, "R2", "unexpected write address", int'(mem_addr), 0);
        else begin
          wr_t e;
          e = exp_q.pop_front();
          check(mem_addr == e.a, "R2", "write address", int'(mem_addr), int'(e.a));
          check(mem_wdata == e.d, "R2", "write data", int'(mem_wdata), int'(e.d));
        end
      end
      prev_stall = mem_req && !mem_ready;
      prev_addr  = mem_addr;
      prev_we    = mem_we;
    end else prev_stall = 1'b0;
  end

  task automatic poke(input int addr, input int data);
    @(negedge clk);
    tb_addr = 10'(addr);
    tb_data = 32'(data);
    tb_wr   = 1'b1;
    @(negedge clk);
    tb_wr   = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int slot, input int a);
    return {8'h5a, 8'(slot), 16'(a)};
  endfunction

  task automatic queue_desc(input int slot, input int src, input int dst,
                            input int len, input bit ie, input int prio);
    int d;
    d = int'(cfg_base) + slot * 4;
    for (int i = 0; i < len; i++) begin
      wr_t e;
      poke(src + i, int'(pat(slot, src + i)));
      e.a = 16'(dst + i);
      e.d = pat(slot, src + i);
      exp_q.push_back(e);
    end
    poke(d + 0, src);
    poke(d + 1, dst);
    poke(d + 2, len);
    poke(d + 3, (prio << 1) | int'(ie));
  endtask

  task automatic wait_head(input int val, input string req);
    int n;
    n = 0;
    while (int'(head_o) != val && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(int'(head_o) == val, req, "head did not reach target", int'(head_o), val);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int r0, w0;
    rst_n = 1'b0; cfg_base = 16'h0100; cfg_size = 5'd4; cfg_tail = 4'd0;
    irq_en = 1'b0; done_clr = 1'b0; tb_wr = 1'b0; tb_addr = '0; tb_data = '0;
    repeat (3) @(negedge clk);
    check(head_o == 0 && !mem_req && !busy && !done_flag && !irq, "R1",
          "state during reset", {head_o, mem_req, busy, done_flag, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(head_o == 0 && !mem_req && !busy && !done_flag && !irq, "R1",
          "state after reset", {head_o, mem_req, busy, done_flag, irq}, 0);

    // R3: empty ring stays quiet
    repeat (20) @(negedge clk);
    check(req_cnt == 0, "R3", "requests with empty ring", req_cnt, 0);

    // R2: single copy, interrupt requested, priority 5
    queue_desc(0, 16'h0200, 16'h0300, 3, 1'b1, 5);
    cfg_tail = 4'd1;
    wait_head(1, "R4");
    check(exp_q.size() == 0, "R2", "writes outstanding", exp_q.size(), 0);
    check(done_flag == 1'b1, "R6", "flag after completion", int'(done_flag), 1);
    check(irq == 1'b0, "R7", "irq with global enable off", int'(irq), 0);
    check(cur_prio == 3'd5, "R9", "priority field", int'(cur_prio), 5);
    req_cnt = 0;
    repeat (10) @(negedge clk);
    check(req_cnt == 0 && head_o == 1, "R3", "idle when head equals tail", req_cnt, 0);
    irq_en = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R7", "irq with global enable on", int'(irq), 1);

    // R6: clear
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    check(!done_flag && !irq, "R6", "flag and irq after clear", {done_flag, irq}, 0);

    // R8: zero length, no interrupt bit
    queue_desc(1, 16'h0000, 16'h0000, 0, 1'b0, 2);
    r0 = rd_cnt; w0 = wr_cnt;
    cfg_tail = 4'd2;
    wait_head(2, "R8");
    check(rd_cnt - r0 == 4, "R8", "reads for empty descriptor", rd_cnt - r0, 4);
    check(wr_cnt == w0, "R8", "writes for empty descriptor", wr_cnt - w0, 0);
    check(done_flag == 1'b1, "R8", "flag after empty descriptor", int'(done_flag), 1);
    check(irq == 1'b0, "R7", "irq without descriptor bit", int'(irq), 0);
    done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;

    // R5/R9: wrap from slot 3 to 0, high priority before low priority
    queue_desc(2, 16'h0210, 16'h0310, 4, 1'b0, 7);
    queue_desc(3, 16'h0220, 16'h0320, 2, 1'b1, 1);
    cfg_tail = 4'd0;
    wait_head(0, "R5");
    check(exp_q.size() == 0, "R9", "ring order writes outstanding", exp_q.size(), 0);
    check(cur_prio == 3'd1, "R9", "last priority", int'(cur_prio), 1);
    check(irq == 1'b1, "R7", "irq from last descriptor", int'(irq), 1);
    done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;

    // R4: append while a long copy runs
    queue_desc(0, 16'h0240, 16'h0340, 24, 1'b0, 0);
    w0 = wr_cnt;
    cfg_tail = 4'd1;
    while (wr_cnt - w0 < 3) @(negedge clk);
    queue_desc(1, 16'h0280, 16'h0380, 2, 1'b0, 3);
    check(busy && head_o == 0, "R4", "tail moved during copy", {busy, head_o}, 16);
    cfg_tail = 4'd2;
    wait_head(2, "R4");
    check(exp_q.size() == 0, "R4", "appended writes outstanding", exp_q.size(), 0);

    // R6: completion and clear in the same cycle
    queue_desc(2, 16'h0290, 16'h0390, 5, 1'b0, 4);
    done_clr = 1'b1;
    @(negedge clk);
    check(done_flag == 1'b0, "R6", "flag while clear held", int'(done_flag), 0);
    cfg_tail = 4'd3;
    while (head_o != 4'd3) @(negedge clk);
    check(done_flag == 1'b1, "R6", "set wins over clear", int'(done_flag), 1);
    done_clr = 1'b0;
    @(negedge clk);
    check(done_flag == 1'b1, "R6", "flag after clear dropped", int'(done_flag), 1);
    check(exp_q.size() == 0, "R2", "final writes outstanding", exp_q.size(), 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule